// File: doc/BRIEF.md
# Load/Store Unit with Alignment Trap

This block carries out the memory instructions of a small 32-bit RISC core against a private 4096-byte data memory. Each request gives a 6-bit opcode, the base register value, the value of the register that supplies store data, and a 16-bit immediate. The block sign-extends the immediate, adds it to the base, and keeps the low 12 bits of the sum as the byte address. It then loads or stores a byte, a halfword or a word.

Loads return a 32-bit result. Byte and halfword results are zero-extended. A write strobe tells the register file to take the result. A halfword or word access whose address is not aligned to its size is not performed. The block raises a trap pulse for it instead. Multi-byte values are held little-endian, so the least significant byte sits at the lowest address.

The results of a request accepted at a rising clock edge appear just after that edge and last one cycle. These results are the trap, the load strobe and the load data.

Top module: `ldst_unit`

## Requirements
- R1: The byte address is (baseVal + sign-extended imm) modulo 4096, so a negative offset subtracts and a sum beyond 4095 wraps around to low addresses.
- R2: Opcode 6'o21 loads the byte at the address, zero-extended into loadData[31:0]. It raises loadWrite for exactly the one cycle after the accepting edge.
- R3: Opcode 6'o22 loads a halfword: the byte at the address goes to bits 7:0 and the next byte goes to bits 15:8, with bits 31:16 zero.
- R4: Opcode 6'o23 loads a word, with the byte at address+k placed in bits 8k+7:8k for k = 0 to 3.
- R5: Opcode 6'o24 stores storeVal[7:0] into the one addressed byte, and leaves every other byte unchanged.
- R6: Opcode 6'o25 stores storeVal[15:0] little-endian into two bytes, and leaves the other bytes unchanged.
- R7: Opcode 6'o26 stores all 32 bits of storeVal little-endian into four bytes.
- R8: A halfword load or store at an address with bit 0 set raises trap for one cycle.
- R9: A word load or store at an address with either of bits 1:0 set raises trap for one cycle.
- R10: A trapping access writes no memory and does not raise loadWrite.
- R11: A request with reqValid low, or with any opcode outside 6'o21..6'o26, writes no memory and raises neither trap nor loadWrite.
- R12: While rstN is low, and in the cycle after it, trap and loadWrite are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| opcode | input | 6 | Instruction opcode |
| baseVal | input | 32 | Base register value |
| storeVal | input | 32 | Store data register value |
| imm | input | 16 | Immediate offset, sign-extended inside the block |
| loadData | output | 32 | Zero-extended load result |
| loadWrite | output | 1 | Register write strobe for loadData |
| trap | output | 1 | Unaligned-access trap pulse |

## Verification
The bench writes known words and then checks each byte and halfword lane on its own. A design with the wrong lane order or wrong endianness would return swapped bytes. A design that sign-extends would return ones above bit 7 or bit 15. A store that spilled into a neighbour lane would show up when the full word is read back. Each misaligned halfword and word access is followed by a read of the location it would have hit. A unit that trapped but still wrote memory, or that checked only bit 1 for words, would leave a changed word or no trap. Negative offsets and sums past 4095 are also covered, so an adder that dropped the sign or failed to wrap would load from the wrong place.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  localparam logic [5:0] OP_LDB = 6'o21;
  localparam logic [5:0] OP_LDH = 6'o22;
  localparam logic [5:0] OP_LDW = 6'o23;
  localparam logic [5:0] OP_STB = 6'o24;
  localparam logic [5:0] OP_STH = 6'o25;
  localparam logic [5:0] OP_STW = 6'o26;

  // strobes from control to datapath for the access of this cycle
  typedef struct packed {
    logic       memWr;
    logic [3:0] byteEn;
    accSize_e   size;
    logic [1:0] laneOfs;
    logic       loadEn;
    logic       trapHit;
  } lsuStrobe_t;

endpackage

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IMM_W  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [5:0]        opcode,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [IMM_W-1:0]  imm,
  output lsuStrobe_t        strb,
  output logic [IDX_W-1:0]  wordIdx,
  output logic              loadWrite,
  output logic              trap
);

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] effAddr;
  logic [ADDR_W-1:0] memAddr;
  logic              isLoad;
  logic              isStore;
  accSize_e          accSize;
  logic              misaligned;
  logic [3:0]        laneMask;

  assign immExt  = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign effAddr = baseVal + immExt;
  assign memAddr = effAddr[ADDR_W-1:0];
  assign wordIdx = memAddr[ADDR_W-1:2];

  always_comb begin
    isLoad  = 1'b0;
    isStore = 1'b0;
    accSize = SZ_BYTE;
    unique case (opcode)
      OP_LDB: begin isLoad = 1'b1;  accSize = SZ_BYTE; end
      OP_LDH: begin isLoad = 1'b1;  accSize = SZ_HALF; end
      OP_LDW: begin isLoad = 1'b1;  accSize = SZ_WORD; end
      OP_STB: begin isStore = 1'b1; accSize = SZ_BYTE; end
      OP_STH: begin isStore = 1'b1; accSize = SZ_HALF; end
      OP_STW: begin isStore = 1'b1; accSize = SZ_WORD; end
      default: ;
    endcase
  end

  always_comb begin
    case (accSize)
      SZ_HALF: misaligned = memAddr[0];
      SZ_WORD: misaligned = |memAddr[1:0];
      default: misaligned = 1'b0;
    endcase
  end

  always_comb begin
    case (accSize)
      SZ_BYTE: laneMask = 4'b0001 << memAddr[1:0];
      SZ_HALF: laneMask = 4'b0011 << memAddr[1:0];
      default: laneMask = 4'b1111;
    endcase
  end

  always_comb begin
    strb.trapHit = reqValid & (isLoad | isStore) & misaligned;
    strb.memWr   = reqValid & isStore & ~misaligned;
    strb.loadEn  = reqValid & isLoad & ~misaligned;
    strb.byteEn  = strb.memWr ? laneMask : 4'b0000;
    strb.size    = accSize;
    strb.laneOfs = memAddr[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadWrite <= 1'b0;
      trap      <= 1'b0;
    end else begin
      loadWrite <= strb.loadEn;
      trap      <= strb.trapHit;
    end
  end

  AST_TRAP_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    trap |-> !loadWrite); // R10
  AST_LOAD_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    loadWrite |-> $past(reqValid)); // R2
  AST_TRAP_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    trap |-> $past(reqValid)); // R8

endmodule

// File: rtl/ldst_datapath.sv
module ldst_datapath
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int IDX_W  = ADDR_W - 2,
  localparam int WORDS  = 1 << IDX_W,
  localparam int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsuStrobe_t        strb,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] storeVal,
  output logic [DATA_W-1:0] loadData
);

  logic [DATA_W-1:0] laneData;
  logic [DATA_W-1:0] rdWordQ;
  logic [DATA_W-1:0] rdShifted;
  logic [1:0]        laneQ;
  accSize_e          sizeQ;

  // replicate store data so every lane offset sees the low bits
  always_comb begin
    case (strb.size)
      SZ_BYTE: laneData = {LANES{storeVal[7:0]}};
      SZ_HALF: laneData = {(LANES/2){storeVal[15:0]}};
      default: laneData = storeVal;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] laneMem [WORDS];
    logic [7:0] rdLaneQ;
    always_ff @(posedge clk) begin
      if (strb.memWr && strb.byteEn[l]) begin
        laneMem[wordIdx] <= laneData[8*l +: 8];
      end
      if (strb.loadEn) begin
        rdLaneQ <= laneMem[wordIdx];
      end
    end
    assign rdWordQ[8*l +: 8] = rdLaneQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneQ <= 2'd0;
      sizeQ <= SZ_WORD;
    end else if (strb.loadEn) begin
      laneQ <= strb.laneOfs;
      sizeQ <= strb.size;
    end
  end

  assign rdShifted = rdWordQ >> {laneQ, 3'b000};

  always_comb begin
    case (sizeQ)
      SZ_BYTE: loadData = {{(DATA_W-8){1'b0}},  rdShifted[7:0]};
      SZ_HALF: loadData = {{(DATA_W-16){1'b0}}, rdShifted[15:0]};
      default: loadData = rdWordQ;
    endcase
  end

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.memWr && strb.size == SZ_BYTE) |-> $countones(strb.byteEn) == 1); // R5
  AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.memWr && strb.size == SZ_HALF) |-> $countones(strb.byteEn) == 2); // R6
  AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.memWr && strb.size == SZ_WORD) |-> strb.byteEn == 4'hF); // R7
  AST_NO_WRITE_ON_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.trapHit |-> !strb.memWr); // R10

endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int MEM_BYTES = 4096,
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 16,
  localparam int ADDR_W   = $clog2(MEM_BYTES),
  localparam int IDX_W    = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [5:0]        opcode,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [DATA_W-1:0] storeVal,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] loadData,
  output logic              loadWrite,
  output logic              trap
);

  lsuStrobe_t       strb;
  logic [IDX_W-1:0] wordIdx;

  ldst_ctrl #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .opcode    (opcode),
    .baseVal   (baseVal),
    .imm       (imm),
    .strb      (strb),
    .wordIdx   (wordIdx),
    .loadWrite (loadWrite),
    .trap      (trap)
  );

  ldst_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wordIdx  (wordIdx),
    .storeVal (storeVal),
    .loadData (loadData)
  );

endmodule

// File: tb/ldst_unit_bench.sv
module ldst_unit_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [5:0]  opcode;
  logic [31:0] baseVal;
  logic [31:0] storeVal;
  logic [15:0] imm;
  logic [31:0] loadData;
  logic        loadWrite;
  logic        trap;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  ldst_unit u_ldst_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opcode(opcode),
    .baseVal(baseVal), .storeVal(storeVal), .imm(imm),
    .loadData(loadData), .loadWrite(loadWrite), .trap(trap)
  );

  typedef struct packed {
    logic [5:0]  op;
    logic [31:0] base;
    logic [15:0] off;
    logic [31:0] sdata;
    logic        expTrap;
    logic        expLd;
    logic [31:0] expData;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 25;
  localparam vec_t VECS [NVEC] = '{
    '{6'o26, 32'h100, 16'h0000, 32'h11223344, 1'b0, 1'b0, 32'h0, 8'd7},        // R7
    '{6'o23, 32'h100, 16'h0000, 32'h0, 1'b0, 1'b1, 32'h11223344, 8'd4},        // R4
    '{6'o21, 32'h0FF, 16'h0002, 32'h0, 1'b0, 1'b1, 32'h00000033, 8'd1},        // R1
    '{6'o22, 32'h104, 16'hFFFC, 32'h0, 1'b0, 1'b1, 32'h00003344, 8'd3},        // R3
    '{6'o22, 32'h102, 16'h0000, 32'h0, 1'b0, 1'b1, 32'h00001122, 8'd3},        // R3
    '{6'o24, 32'h102, 16'h0000, 32'hFFFFFFAA, 1'b0, 1'b0, 32'h0, 8'd5},        // R5
    '{6'o23, 32'h100, 16'h0000, 32'h0, 1'b0, 1'b1, 32'h11AA3344, 8'd5},        // R5
    '{6'o25, 32'h100, 16'h0000, 32'hDEADBEEF, 1'b0, 1'b0, 32'h0, 8'd6},        // R6
    '{6'o23, 32'h100, 16'h0000, 32'h0, 1'b0, 1'b1, 32'h11AABEEF, 8'd6},        // R6
    '{6'o21, 32'h100, 16'h0000, 32'h0, 1'b0, 1'b1, 32'h000000EF, 8'd2},        // R2
    '{6'o22, 32'h101, 16'h0000, 32'h0, 1'b1, 1'b0, 32'h0, 8'd8},               // R8
    '{6'o25, 32'h103, 16'h0000, 32'h5555, 1'b1, 1'b0, 32'h0, 8'd8},            // R8
    '{6'o23, 32'h100, 16'h0000, 32'h0, 1'b0, 1'b1, 32'h11AABEEF, 8'd10},       // R10
    '{6'o23, 32'h102, 16'h0000, 32'h0, 1'b1, 1'b0, 32'h0, 8'd9},               // R9
    '{6'o26, 32'h101, 16'h0000, 32'h0, 1'b1, 1'b0, 32'h0, 8'd9},               // R9
    '{6'o23, 32'h100, 16'h0000, 32'h0, 1'b0, 1'b1, 32'h11AABEEF, 8'd10},       // R10
    '{6'o26, 32'hFFE, 16'h0006, 32'hCAFEF00D, 1'b0, 1'b0, 32'h0, 8'd1},        // R1
    '{6'o23, 32'h004, 16'h0000, 32'h0, 1'b0, 1'b1, 32'hCAFEF00D, 8'd1},        // R1
    '{6'o20, 32'h004, 16'h0000, 32'h0, 1'b0, 1'b0, 32'h0, 8'd11},              // R11
    '{6'o27, 32'h004, 16'h0000, 32'h0, 1'b0, 1'b0, 32'h0, 8'd11},              // R11
    '{6'o23, 32'h004, 16'h0000, 32'h0, 1'b0, 1'b1, 32'hCAFEF00D, 8'd11},       // R11
    '{6'o24, 32'h000, 16'h0000, 32'h0000007E, 1'b0, 1'b0, 32'h0, 8'd5},        // R5
    '{6'o21, 32'hFFFFFFFF, 16'h0001, 32'h0, 1'b0, 1'b1, 32'h0000007E, 8'd1},   // R1
    '{6'o22, 32'h006, 16'h0000, 32'h0, 1'b0, 1'b1, 32'h0000CAFE, 8'd3},        // R3
    '{6'o21, 32'h007, 16'h0000, 32'h0, 1'b0, 1'b1, 32'h000000CA, 8'd2}         // R2
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge accept, sample at the next falling edge
  task automatic runOp(input logic v, input logic [5:0] op, input logic [31:0] b,
                       input logic [15:0] o, input logic [31:0] sd);
    reqValid = v; opcode = op; baseVal = b; imm = o; storeVal = sd;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; opcode = 6'o0; baseVal = 0; storeVal = 0; imm = 0;
    repeat (3) @(negedge clk);
    check("R12 trap in reset", {31'b0, trap}, 32'h0);
    check("R12 loadWrite in reset", {31'b0, loadWrite}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R12 trap after reset", {31'b0, trap}, 32'h0);
    check("R12 loadWrite after reset", {31'b0, loadWrite}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      runOp(1'b1, VECS[i].op, VECS[i].base, VECS[i].off, VECS[i].sdata);
      testsRun++;
      if (trap !== VECS[i].expTrap || loadWrite !== VECS[i].expLd ||
          (VECS[i].expLd && loadData !== VECS[i].expData)) begin
        testsFailed++;
        $display("FAIL R%0d vector %0d: actual trap=%b ld=%b data=%h expected trap=%b ld=%b data=%h",
                 VECS[i].req, i, trap, loadWrite, loadData,
                 VECS[i].expTrap, VECS[i].expLd, VECS[i].expData);
      end
    end

    // R2: strobe lasts one cycle only
    @(negedge clk);
    check("R2 loadWrite pulse ends", {31'b0, loadWrite}, 32'h0);

    // R11: requests with reqValid low have no effect
    runOp(1'b1, 6'o26, 32'h200, 16'h0, 32'h01020304);
    runOp(1'b0, 6'o26, 32'h200, 16'h0, 32'hFFFFFFFF);
    check("R11 no trap when idle", {31'b0, trap}, 32'h0);
    check("R11 no loadWrite when idle store", {31'b0, loadWrite}, 32'h0);
    runOp(1'b0, 6'o23, 32'h200, 16'h0, 32'h0);
    check("R11 no loadWrite for idle load", {31'b0, loadWrite}, 32'h0);
    runOp(1'b0, 6'o23, 32'h201, 16'h0, 32'h0);
    check("R11 no trap for idle misaligned", {31'b0, trap}, 32'h0);
    runOp(1'b1, 6'o23, 32'h200, 16'h0, 32'h0);
    check("R11 memory kept after idle store", loadData, 32'h01020304);

    // R12: reset in mid-run clears a pending trap
    reqValid = 1'b1; opcode = 6'o23; baseVal = 32'h203; imm = 0;
    rstN = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    check("R12 trap held low in reset", {31'b0, trap}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R12 loadWrite low after reset", {31'b0, loadWrite}, 32'h0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule